// File: doc/BRIEF.md
# Video Timing-Code Capture Filter

This block watches a parallel byte stream of interleaved digital video that carries embedded timing reference codes. It passes on only the bytes that a programmable capture mode selects. After reset it forwards nothing. It decodes each timing code in the stream and waits for the start of field 1. From that point it forwards one of three selections: the active-video bytes of a programmed number of lines per frame, the bytes of vertical-blanking lines, or the whole stream without exception.

Each forwarded byte leaves on a registered output with a valid strobe. Three flags go with it: the field bit, the vertical-blanking bit and the horizontal-blanking bit of the most recent timing code. A small write port selects the mode and sets the line count. A mode write stops capture and makes the block search for sync again. The new mode and the pending line count are both applied at the next field 1 start.

States: `ST_SEARCH` (hunting for field 1), `ST_WAIT_SAV` (active mode, discarding until a start-of-active-video code on a non-blanking line), `ST_ACTIVE` (forwarding line bytes), `ST_DONE` (line quota used up), `ST_VBI` (blanking-line capture), `ST_ALL` (whole-field capture). Transitions:
- Any state goes to `ST_SEARCH` on a legal mode write.
- Any state goes to the entry state of the pending mode on a field 1 start. The entry states are `ST_WAIT_SAV`, `ST_VBI` and `ST_ALL`.
- `ST_WAIT_SAV` goes to `ST_ACTIVE` on a start code with V=0 while the quota is not reached.
- `ST_ACTIVE` goes to `ST_WAIT_SAV` on an end code, or to `ST_DONE` when that end code completes the quota.

Top module: `vid_stream_capture`

## Requirements
- R1: While reset is held and after its release, `cap_valid_o` is 0. The mode resets to active-video (code 0) and the line count to parameter `DEF_LINES`.
- R2: No byte is forwarded until a field 1 start. A field 1 start is a timing code whose F bit is 0 while the previous decoded timing code had F=1. The field 1 start code itself is not forwarded when it ends a search.
- R3: A timing code is the byte run 0xFF, 0x00, 0x00, XY with XY bit 7 = 1. In XY, bit 6 is F, bit 5 is V, and bit 4 is H (0 = start of active video, 1 = end of active video). A run whose fourth byte has bit 7 = 0 is not a code.
- R4: In active-video mode (code 0), bytes are discarded after sync until a start code with V=0. The bytes that follow it are forwarded up to the next end code. No byte of any timing code (0xFF, 0x00, 0x00, XY) is forwarded in this mode.
- R5: A line counter is cleared at every field 1 start and advanced by each end code that closes a forwarded line. Once it equals the line count, nothing more is forwarded until the next field 1 start. A count of 0 forwards nothing. A written count takes effect at the next field 1 start.
- R6: In blanking mode (code 1), a byte is forwarded exactly when it is not part of a timing code and the most recent code had V=1.
- R7: In entire-field mode (code 2), every byte after the sync code is forwarded, timing codes included. Later field 1 start codes are forwarded too.
- R8: A write of code 0, 1 or 2 to address 0 halts forwarding at once and returns the block to sync search. The new mode applies from the next field 1 start.
- R9: A write of code 3 to address 0 is ignored. The current capture continues without resync.
- R10: A forwarded byte appears one clock after it is presented, with `cap_valid_o` high for one cycle. Its F, V and H flags are those of the latest timing code, including a code ending on that same byte. Cycles with `vid_valid_i` low give no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vid_data_i | input | 8 | Incoming video byte |
| vid_valid_i | input | 1 | Byte on `vid_data_i` is present this cycle |
| cfg_wr_i | input | 1 | Write strobe for the setup port |
| cfg_addr_i | input | 1 | 0 = capture mode (bits 1:0), 1 = line count |
| cfg_wdata_i | input | LINE_W | Write data |
| cap_data_o | output | 8 | Forwarded byte |
| cap_valid_o | output | 1 | Forwarded byte strobe |
| cap_field_o | output | 1 | F flag of latest timing code |
| cap_vblank_o | output | 1 | V flag of latest timing code |
| cap_hblank_o | output | 1 | H flag of latest timing code |

## Verification
The properties assume that 0xFF occurs in the stream only as the lead byte of a timing code. That holds for this video format, where 0x00 and 0xFF are reserved. The properties also assume that setup writes do not depend on the stream position. The stimulus builds every line from well-formed codes, with blanking and picture bytes kept between 0x10 and 0xE7. Its only malformed run is a deliberate one, whose fourth byte has bit 7 clear. Setup writes are issued on cycles with no valid byte, and gaps in `vid_valid_i` are inserted without splitting a timing code in a way that changes its meaning.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_VBI    = 2'd1,
        MODE_FIELD  = 2'd2
    } cap_mode_e;

    typedef enum logic [2:0] {
        ST_SEARCH,
        ST_WAIT_SAV,
        ST_ACTIVE,
        ST_DONE,
        ST_VBI,
        ST_ALL
    } cap_state_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_LEAD,
        P_ZERO1,
        P_ZERO2
    } trs_pos_e;

    localparam logic [7:0] TRS_LEAD = 8'hFF;
    localparam logic [7:0] TRS_ZERO = 8'h00;
    localparam int XY_MARK_BIT = 7;
    localparam int XY_F_BIT    = 6;
    localparam int XY_V_BIT    = 5;
    localparam int XY_H_BIT    = 4;

endpackage

// File: rtl/vcap_trs_decoder.sv
module vcap_trs_decoder
    import vcap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       trs_byte_o,
    output logic       xy_hit_o,
    output logic       f1_start_o,
    output logic       f_now_o,
    output logic       v_now_o,
    output logic       h_now_o
);

    trs_pos_e pos_q, pos_d;
    logic     f_q, v_q, h_q, f_known_q;

    always_comb begin
        xy_hit_o   = valid_i && (pos_q == P_ZERO2) && data_i[XY_MARK_BIT];
        trs_byte_o = valid_i && ((pos_q != P_IDLE) || (data_i == TRS_LEAD));
        f1_start_o = xy_hit_o && f_known_q && f_q && !data_i[XY_F_BIT];
        f_now_o    = xy_hit_o ? data_i[XY_F_BIT] : f_q;
        v_now_o    = xy_hit_o ? data_i[XY_V_BIT] : v_q;
        h_now_o    = xy_hit_o ? data_i[XY_H_BIT] : h_q;
    end

    always_comb begin
        pos_d = pos_q;
        if (valid_i) begin
            unique case (pos_q)
                P_IDLE:  pos_d = (data_i == TRS_LEAD) ? P_LEAD : P_IDLE;
                P_LEAD:  pos_d = (data_i == TRS_ZERO) ? P_ZERO1 :
                                 (data_i == TRS_LEAD) ? P_LEAD : P_IDLE;
                P_ZERO1: pos_d = (data_i == TRS_ZERO) ? P_ZERO2 :
                                 (data_i == TRS_LEAD) ? P_LEAD : P_IDLE;
                P_ZERO2: pos_d = P_IDLE;
                default: pos_d = P_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pos_q     <= P_IDLE;
            f_q       <= 1'b0;
            v_q       <= 1'b0;
            h_q       <= 1'b0;
            f_known_q <= 1'b0;
        end else begin
            pos_q <= pos_d;
            if (xy_hit_o) begin
                f_q       <= data_i[XY_F_BIT];
                v_q       <= data_i[XY_V_BIT];
                h_q       <= data_i[XY_H_BIT];
                f_known_q <= 1'b1;
            end
        end
    end

    AST_F1_LEAVES_F_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f1_start_o |=> !f_q); // R2

    AST_CODE_NEEDS_PREAMBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && pos_q == P_IDLE) |-> !xy_hit_o); // R3

endmodule

// File: rtl/vcap_cfg_regs.sv
module vcap_cfg_regs
    import vcap_pkg::*;
#(
    parameter int LINE_W    = 11,
    parameter int DEF_LINES = 487
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [LINE_W-1:0] wdata_i,
    input  logic              apply_i,
    output cap_mode_e         pend_mode_o,
    output logic [LINE_W-1:0] target_o,
    output logic              resync_o
);

    localparam logic [LINE_W-1:0] LINES_RST = LINE_W'(DEF_LINES);

    logic [LINE_W-1:0] cnt_pend_q;
    logic              mode_legal;

    assign mode_legal = (wdata_i[1:0] != 2'b11);
    assign resync_o   = wr_i && !addr_i && mode_legal;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_mode_o <= MODE_ACTIVE;
            cnt_pend_q  <= LINES_RST;
            target_o    <= LINES_RST;
        end else begin
            if (resync_o)
                pend_mode_o <= cap_mode_e'(wdata_i[1:0]);
            if (wr_i && addr_i)
                cnt_pend_q <= wdata_i;
            if (apply_i)
                target_o <= cnt_pend_q;
        end
    end

    AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_mode_o != 2'b11); // R9

    AST_BAD_MODE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !addr_i && !mode_legal) |=> $stable(pend_mode_o)); // R9

endmodule

// File: rtl/vcap_line_ctr.sv
module vcap_line_ctr #(
    parameter int LINE_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [LINE_W-1:0] tgt_i,
    output logic              last_o,
    output logic              reached_o
);

    localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

    logic [LINE_W-1:0] cnt_q;

    assign last_o    = ((cnt_q + ONE) == tgt_i);
    assign reached_o = (cnt_q >= tgt_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (inc_i)
            cnt_q <= cnt_q + ONE;
    end

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_i |-> (cnt_q < tgt_i)); // R5

    AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/vid_stream_capture.sv
module vid_stream_capture
    import vcap_pkg::*;
#(
    parameter int LINE_W    = 11,
    parameter int DEF_LINES = 487
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [7:0]        vid_data_i,
    input  logic              vid_valid_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_addr_i,
    input  logic [LINE_W-1:0] cfg_wdata_i,
    output logic [7:0]        cap_data_o,
    output logic              cap_valid_o,
    output logic              cap_field_o,
    output logic              cap_vblank_o,
    output logic              cap_hblank_o
);

    cap_state_e        state_q, state_d;
    cap_mode_e         pend_mode;
    logic [LINE_W-1:0] target;
    logic              resync, trs_byte, xy_hit, f1_start;
    logic              f_now, v_now, h_now;
    logic              ctr_clr, ctr_inc, ctr_last, ctr_reached;
    logic              fwd;

    vcap_trs_decoder u_dec (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .data_i     (vid_data_i),
        .valid_i    (vid_valid_i),
        .trs_byte_o (trs_byte),
        .xy_hit_o   (xy_hit),
        .f1_start_o (f1_start),
        .f_now_o    (f_now),
        .v_now_o    (v_now),
        .h_now_o    (h_now)
    );

    vcap_cfg_regs #(.LINE_W(LINE_W), .DEF_LINES(DEF_LINES)) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (cfg_wr_i),
        .addr_i      (cfg_addr_i),
        .wdata_i     (cfg_wdata_i),
        .apply_i     (f1_start),
        .pend_mode_o (pend_mode),
        .target_o    (target),
        .resync_o    (resync)
    );

    vcap_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (ctr_clr),
        .inc_i     (ctr_inc),
        .tgt_i     (target),
        .last_o    (ctr_last),
        .reached_o (ctr_reached)
    );

    function automatic cap_state_e entry_state(input cap_mode_e m);
        unique case (m)
            MODE_VBI:   return ST_VBI;
            MODE_FIELD: return ST_ALL;
            default:    return ST_WAIT_SAV;
        endcase
    endfunction

    assign ctr_clr = f1_start;
    assign ctr_inc = (state_q == ST_ACTIVE) && xy_hit && h_now && !f1_start && !resync;

    always_comb begin
        state_d = state_q;
        if (resync) begin
            state_d = ST_SEARCH;
        end else if (f1_start) begin
            state_d = entry_state(pend_mode);
        end else begin
            unique case (state_q)
                ST_WAIT_SAV:
                    if (xy_hit && !h_now && !v_now && !ctr_reached)
                        state_d = ST_ACTIVE;
                ST_ACTIVE:
                    if (xy_hit && h_now)
                        state_d = ctr_last ? ST_DONE : ST_WAIT_SAV;
                ST_SEARCH, ST_DONE, ST_VBI, ST_ALL:
                    state_d = state_q;
                default:
                    state_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            state_q <= ST_SEARCH;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ACTIVE: fwd = !trs_byte;
            ST_VBI:    fwd = !trs_byte && v_now;
            ST_ALL:    fwd = 1'b1;
            default:   fwd = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_valid_o  <= 1'b0;
            cap_data_o   <= '0;
            cap_field_o  <= 1'b0;
            cap_vblank_o <= 1'b0;
            cap_hblank_o <= 1'b0;
        end else begin
            cap_valid_o <= vid_valid_i && fwd;
            if (vid_valid_i) begin
                cap_data_o   <= vid_data_i;
                cap_field_o  <= f_now;
                cap_vblank_o <= v_now;
                cap_hblank_o <= h_now;
            end
        end
    end

    AST_SEARCH_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEARCH) |=> !cap_valid_o); // R2

    AST_NO_CODE_IN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACTIVE && trs_byte) |=> !cap_valid_o); // R4

    AST_DONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DONE) |=> !cap_valid_o); // R5

    AST_RESYNC_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resync |=> (state_q == ST_SEARCH)); // R8

    AST_OUT_NEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_valid_o |-> $past(vid_valid_i)); // R10

endmodule

// File: tb/vid_stream_capture_tb_top.sv
module vid_stream_capture_tb_top;

    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    vid_data = '0;
    logic          vid_valid = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [LW-1:0] cfg_wdata = '0;
    logic [7:0]    cap_data;
    logic          cap_valid, cap_field, cap_vblank, cap_hblank;

    always #10 clk = ~clk;

    vid_stream_capture #(.LINE_W(LW), .DEF_LINES(487)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .vid_data_i   (vid_data),
        .vid_valid_i  (vid_valid),
        .cfg_wr_i     (cfg_wr),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .cap_data_o   (cap_data),
        .cap_valid_o  (cap_valid),
        .cap_field_o  (cap_field),
        .cap_vblank_o (cap_vblank),
        .cap_hblank_o (cap_hblank)
    );

    typedef struct {
        logic [7:0] d;
        logic       f, v, h;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   unexp  = 0;
    int   cycles = 0;
    bit   done   = 0;
    logic cur_f = 0, cur_v = 0, cur_h = 0;
    int   seed = 0;

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R10: actual %0d cycles expected below 100000", cycles);
            report();
        end
    end

    // Scoreboard monitor
    always begin
        @(posedge clk);
        #2;
        if (rst_n && cap_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                unexp++;
                $display("FAIL unexpected output R2/R10: actual %02h expected none", cap_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (cap_data !== e.d || cap_field !== e.f || cap_vblank !== e.v || cap_hblank !== e.h) begin
                    errors++;
                    $display("FAIL %s: actual %02h f%0b v%0b h%0b expected %02h f%0b v%0b h%0b",
                             e.tag, cap_data, cap_field, cap_vblank, cap_hblank, e.d, e.f, e.v, e.h);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b, input bit is_xy, input bit exp, input string tag);
        exp_t e;
        @(negedge clk);
        vid_data  = b;
        vid_valid = 1'b1;
        if (is_xy) begin
            cur_f = b[6];
            cur_v = b[5];
            cur_h = b[4];
        end
        if (exp) begin
            e.d = b; e.f = cur_f; e.v = cur_v; e.h = cur_h; e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vid_valid = 1'b0;
        end
    endtask

    task automatic cfg_write(input bit a, input int val);
        @(negedge clk);
        vid_valid = 1'b0;
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = LW'(val);
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // One line: end code, blanking, start code, picture bytes
    task automatic send_line(input bit f, input bit v, input bit fe, input bit fs,
                             input bit fb, input bit fa, input string tag);
        logic [7:0] xe, xs;
        xe = {1'b1, f, v, 1'b1, 4'h0};
        xs = {1'b1, f, v, 1'b0, 4'h0};
        put(8'hFF, 0, fe, tag); put(8'h00, 0, fe, tag); put(8'h00, 0, fe, tag); put(xe, 1, fe, tag);
        for (int i = 0; i < 4; i++) put(i[0] ? 8'h10 : 8'h80, 0, fb, tag);
        put(8'hFF, 0, fs, tag); put(8'h00, 0, fs, tag); put(8'h00, 0, fs, tag); put(xs, 1, fs, tag);
        for (int i = 0; i < 6; i++) begin
            put(8'(8'h20 + (seed % 200)), 0, fa, tag);
            seed = seed + 7;
        end
    endtask

    task automatic phase_check(input string tag);
        idle(3);
        checks++;
        if (q.size() != 0 || unexp != 0) begin
            errors++;
            $display("FAIL %s: actual pending %0d unexpected %0d expected 0 and 0", tag, q.size(), unexp);
        end
        q.delete();
        unexp = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        checks++; // R1 reset state
        if (cap_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual cap_valid %0b expected 0", cap_valid);
        end
        rst_n = 1'b1;
        idle(2);
        checks++; // R1 after release
        if (cap_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual cap_valid %0b expected 0 after release", cap_valid);
        end

        cfg_write(1, 2);
        // R2: no field 1 start yet
        send_line(0, 0, 0, 0, 0, 0, "R2");
        send_line(1, 1, 0, 0, 0, 0, "R2");
        send_line(1, 0, 0, 0, 0, 0, "R2");
        phase_check("R2");

        // R3: run whose fourth byte lacks bit 7 is not a code
        put(8'hFF, 0, 0, "R3"); put(8'h00, 0, 0, "R3"); put(8'h00, 0, 0, "R3"); put(8'h00, 0, 0, "R3");
        send_line(1, 0, 0, 0, 0, 0, "R3");
        phase_check("R3");

        // R4/R5: active mode, two lines
        send_line(0, 1, 0, 0, 0, 0, "R4");
        send_line(0, 1, 0, 0, 0, 0, "R4");
        send_line(0, 0, 0, 0, 0, 1, "R4");
        send_line(0, 0, 0, 0, 0, 1, "R4");
        phase_check("R4");
        send_line(0, 0, 0, 0, 0, 0, "R5");
        send_line(0, 0, 0, 0, 0, 0, "R5");
        send_line(1, 1, 0, 0, 0, 0, "R5");
        send_line(1, 0, 0, 0, 0, 0, "R5");
        phase_check("R5");
        send_line(0, 1, 0, 0, 0, 0, "R5");
        send_line(0, 0, 0, 0, 0, 1, "R5");
        send_line(0, 0, 0, 0, 0, 1, "R5");
        send_line(0, 0, 0, 0, 0, 0, "R5");
        phase_check("R5");

        // R8/R6: switch to blanking mode
        cfg_write(0, 1);
        send_line(0, 0, 0, 0, 0, 0, "R8");
        send_line(1, 1, 0, 0, 0, 0, "R8");
        phase_check("R8");
        send_line(0, 1, 0, 0, 1, 1, "R6");
        send_line(0, 1, 0, 0, 1, 1, "R6");
        send_line(0, 0, 0, 0, 0, 0, "R6");
        phase_check("R6");

        // R9: illegal mode code ignored
        cfg_write(0, 3);
        send_line(0, 1, 0, 0, 1, 1, "R9");
        phase_check("R9");

        // R7: entire field mode
        cfg_write(0, 2);
        send_line(0, 1, 0, 0, 0, 0, "R7");
        send_line(1, 1, 0, 0, 0, 0, "R7");
        send_line(0, 1, 0, 1, 1, 1, "R7");
        send_line(0, 0, 1, 1, 1, 1, "R7");
        send_line(1, 0, 1, 1, 1, 1, "R7");
        send_line(0, 1, 1, 1, 1, 1, "R7");
        phase_check("R7");

        // R10: gaps in the valid strobe
        put(8'h44, 0, 1, "R10");
        idle(3);
        put(8'h55, 0, 1, "R10");
        idle(1);
        put(8'hFF, 0, 1, "R10"); put(8'h00, 0, 1, "R10"); idle(2);
        put(8'h00, 0, 1, "R10"); put(8'hB0, 1, 1, "R10");
        put(8'h66, 0, 1, "R10");
        phase_check("R10");

        // R5: count of zero forwards nothing
        cfg_write(1, 0);
        cfg_write(0, 0);
        send_line(1, 1, 0, 0, 0, 0, "R5");
        send_line(0, 1, 0, 0, 0, 0, "R5");
        send_line(0, 0, 0, 0, 0, 0, "R5");
        send_line(0, 0, 0, 0, 0, 0, "R5");
        phase_check("R5");

        done = 1;
        report();
    end

endmodule